// File: doc/BRIEF.md
# Strap-Addressed I2C Register Target

This block is an I2C target that serves a 16-entry byte register window. Its bus address pair is picked by a strap input. The strap is captured at the moment the active-low reset is released, and later changes on the strap pin have no effect. With the strap low, the target answers to write address 0xC2 and read address 0xC3 (7-bit 0x61). With the strap high, it answers to 0xC8 and 0xC9 (7-bit 0x64).

Every transfer carries a header byte right after the address byte. The header's low four bits give the starting index into the window.
- In a write, the data bytes that follow are stored at consecutive indices.
- In a read, the target then shifts out window bytes MSB first from that index, while the master writes SDA high. It keeps going as long as the master acknowledges, and stops at the first missing acknowledge.

A local port lets the surrounding logic preload and inspect the window. A strap-released flag rises a fixed number of clocks after reset ends, so that a pin shared between the strap and another function can be handed back.

SCL and SDA are oversampled on the system clock and modelled as open drain: the block sees the bus levels and only ever pulls SDA low. The system clock must run well above SCL. Bus rates up to 500 kHz call for a clock of at least about 16 MHz.

Top module: `i2c_strap_target`

## Requirements
- R1: With strap low at reset release, address byte 0xC2 (write) and 0xC3 (read) are acknowledged, and 0xC8 is not.
- R2: With strap high at reset release, address bytes 0xC8/0xC9 are acknowledged, and 0xC2 is not.
- R3: A strap change after reset release does not change the address the target answers to.
- R4: strap_rel is low during reset, low for the first REL_CYCLES-1 clocks after release, high from the REL_CYCLES-th clock on, and then stays high.
- R5: The target acknowledges a matching address byte, the header byte and every write data byte by pulling SDA low during the 9th SCL pulse. After an address mismatch it acknowledges nothing and changes no register until the next START.
- R6: Header bits [3:0] set the start index. Each write data byte goes to the current index, and the index then increments, wrapping from 15 to 0.
- R7: In a read, after the header the target drives window bytes MSB first from the start index, with the index incrementing, for as long as the master acknowledges each byte.
- R8: A master NACK ends the read. The target then releases SDA, so further clocks read 0xFF, until the next START.
- R9: A repeated START without a STOP restarts address matching.
- R10: SDA drive changes only while SCL is low, and a STOP leaves SDA released.
- R11: loc_rdata shows the entry selected by loc_idx, and loc_we writes loc_wdata into that entry. Reset clears all entries to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low reset; strap captured on its release |
| strap | input | 1 | Address select strap |
| strap_rel | output | 1 | High once the strap pin may be reused |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| sda_oe | output | 1 | 1 pulls SDA low |
| loc_we | input | 1 | Local write enable |
| loc_idx | input | 4 | Local entry index |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Entry at loc_idx |

## Verification
The bench changes the strap after reset to prove that it is ignored. A design that kept sampling the strap would answer the wrong address. A start index of 14 with three data bytes checks wraparound: a design that does not wrap would lose the third byte. The bench keeps clocking after a read NACK, where a design that ignored the NACK would keep driving data bits, and it sends a foreign address followed by a repeated START, which catches a design that stays deaf until a STOP. Sending data after an address mismatch exposes a target that latches bytes it was never addressed for.

// File: rtl/i2c_strap_target.sv
module i2c_strap_target #(
  parameter int NREGS = 16,
  parameter int REL_CYCLES = 8,
  parameter logic [6:0] ADDR_LO = 7'h61,
  parameter logic [6:0] ADDR_HI = 7'h64,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap,
  output logic             strap_rel,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic             loc_we,
  input  logic [IDX_W-1:0] loc_idx,
  input  logic [7:0]       loc_wdata,
  output logic [7:0]       loc_rdata
);
  localparam int CW = $clog2(REL_CYCLES + 1);
  localparam logic [3:0] S_IDLE = 4'd0, S_ADDR = 4'd1, S_AACK = 4'd2,
                         S_HDR = 4'd3, S_HACK = 4'd4, S_WR = 4'd5,
                         S_WACK = 4'd6, S_RD = 4'd7, S_RACK = 4'd8;

  logic [2:0] scl_sr, sda_sr;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic sel;
  logic [CW-1:0] rel_cnt;
  logic [3:0] st, bitcnt;
  logic [7:0] sh, tx;
  logic [IDX_W-1:0] idx;
  logic rw, mack, rx_state;
  logic [6:0] my_addr;
  logic [7:0] regs [NREGS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sr <= 3'b111;
      sda_sr <= 3'b111;
    end else begin
      scl_sr <= {scl_sr[1:0], scl_i};
      sda_sr <= {sda_sr[1:0], sda_i};
    end

  assign scl_rise = scl_sr[1] & ~scl_sr[2];
  assign scl_fall = ~scl_sr[1] & scl_sr[2];
  assign start_ev = scl_sr[1] & scl_sr[2] & ~sda_sr[1] & sda_sr[2];
  assign stop_ev  = scl_sr[1] & scl_sr[2] & sda_sr[1] & ~sda_sr[2];

  always_ff @(posedge clk)
    if (!rst_n) sel <= strap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rel_cnt <= '0;
    else if (rel_cnt != CW'(REL_CYCLES)) rel_cnt <= rel_cnt + 1'b1;

  assign strap_rel = (rel_cnt == CW'(REL_CYCLES));
  assign my_addr   = sel ? ADDR_HI : ADDR_LO;
  assign rx_state  = (st == S_ADDR) || (st == S_HDR) || (st == S_WR);
  assign loc_rdata = regs[loc_idx];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; sh <= '0; tx <= '0; idx <= '0;
      rw <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      if (loc_we) regs[loc_idx] <= loc_wdata;
      if (start_ev) begin
        st <= S_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else if (scl_rise) begin
        if (rx_state) begin
          sh <= {sh[6:0], sda_sr[1]};
          bitcnt <= bitcnt + 4'd1;
        end else if (st == S_RD) bitcnt <= bitcnt + 4'd1;
        else if (st == S_RACK) mack <= ~sda_sr[1];
      end else if (scl_fall) begin
        case (st)
          S_ADDR: if (bitcnt == 4'd8) begin
            if (sh[7:1] == my_addr) begin
              rw <= sh[0]; sda_oe <= 1'b1; st <= S_AACK;
            end else st <= S_IDLE;
          end
          S_HDR: if (bitcnt == 4'd8) begin
            idx <= sh[IDX_W-1:0]; sda_oe <= 1'b1; st <= S_HACK;
          end
          S_WR: if (bitcnt == 4'd8) begin
            regs[idx] <= sh; idx <= idx + 1'b1; sda_oe <= 1'b1; st <= S_WACK;
          end
          S_AACK, S_WACK: begin
            sda_oe <= 1'b0; bitcnt <= '0; st <= (st == S_AACK) ? S_HDR : S_WR;
          end
          S_HACK, S_RACK: begin
            if ((st == S_HACK && rw) || (st == S_RACK && mack)) begin
              tx <= regs[idx]; sda_oe <= ~regs[idx][7]; idx <= idx + 1'b1;
              bitcnt <= '0; st <= S_RD;
            end else if (st == S_HACK) begin
              sda_oe <= 1'b0; bitcnt <= '0; st <= S_WR;
            end else begin
              sda_oe <= 1'b0; st <= S_IDLE;
            end
          end
          S_RD: if (bitcnt == 4'd8) begin
            sda_oe <= 1'b0; st <= S_RACK;
          end else begin
            sda_oe <= ~tx[6]; tx <= {tx[6:0], 1'b0};
          end
          default: ;
        endcase
      end
    end
endmodule

module i2c_strap_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       strap_rel,
  input logic       sel,
  input logic [3:0] st,
  input logic       stop_ev
);
  // R10
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe));
  // R10
  stop_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!sda_oe && st == 4'd0));
  // R4
  rel_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_rel |=> strap_rel);
  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(sel));
  // R5
  oe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == 4'd2 || st == 4'd4 || st == 4'd6 || st == 4'd7));
endmodule

bind i2c_strap_target i2c_strap_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .strap_rel(strap_rel), .sel(sel), .st(st), .stop_ev(stop_ev)
);

// File: tb/test_i2c_strap_target.sv
module test_i2c_strap_target;
  localparam int CLK_NS = 10;
  localparam int Q = 8;
  localparam int REL = 8;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0, scl = 1'b1, msda = 1'b1;
  logic loc_we = 1'b0;
  logic [3:0] loc_idx = '0;
  logic [7:0] loc_wdata = '0;
  logic sda_oe, strap_rel;
  logic [7:0] loc_rdata;
  logic sda_bus;
  assign sda_bus = msda & ~sda_oe;

  always #(CLK_NS/2) clk = ~clk;

  i2c_strap_target #(.REL_CYCLES(REL)) i_i2c_strap_target (
    .clk(clk), .rst_n(rst_n), .strap(strap), .strap_rel(strap_rel),
    .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .loc_we(loc_we), .loc_idx(loc_idx), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
  );

  int n_run = 0, n_fail = 0;
  int exp_q[$], obs_q[$];
  string tag_q[$];

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_item(string t, int v);
    tag_q.push_back(t); exp_q.push_back(v);
  endtask

  initial forever begin
    string t; int o, e;
    wait (obs_q.size() > 0);
    o = obs_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
    check(t, o, e);
  end

  task automatic tick(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); tick(); msda = 1'b0; tick(); scl = 1'b0; tick(); endtask
  task automatic bus_rstart(); msda = 1'b1; tick(); scl = 1'b1; tick(); msda = 1'b0; tick(); scl = 1'b0; tick(); endtask
  task automatic bus_stop(); msda = 1'b0; tick(); scl = 1'b1; tick(); msda = 1'b1; tick(); endtask
  task automatic bit_out(logic v); msda = v; tick(); scl = 1'b1; tick(); tick(); scl = 1'b0; tick(); endtask
  task automatic bit_in(output logic r); msda = 1'b1; tick(); scl = 1'b1; tick(); r = sda_bus; tick(); scl = 1'b0; tick(); endtask

  task automatic wr_byte(logic [7:0] b);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    obs_q.push_back(a == 1'b0 ? 1 : 0);
  endtask

  task automatic rd_byte(logic ack);
    logic [7:0] d; logic r;
    for (int i = 7; i >= 0; i--) begin bit_in(r); d[i] = r; end
    bit_out(~ack);
    obs_q.push_back(int'(d));
  endtask

  task automatic loc_write(logic [3:0] i, logic [7:0] v);
    @(negedge clk); loc_idx = i; loc_wdata = v; loc_we = 1'b1;
    @(negedge clk); loc_we = 1'b0;
  endtask

  task automatic loc_check(string req, logic [3:0] i, int v);
    @(negedge clk); loc_idx = i; #1; check(req, int'(loc_rdata), v);
  endtask

  task automatic do_reset(logic s);
    @(negedge clk); rst_n = 1'b0; strap = s;
    repeat (5) @(negedge clk);
    check("R4 rel low in reset", int'(strap_rel), 0);
    rst_n = 1'b1;
    repeat (REL - 1) @(negedge clk);
    check("R4 rel low before count", int'(strap_rel), 0);
    @(negedge clk);
    check("R4 rel high at count", int'(strap_rel), 1);
    repeat (2) @(negedge clk);
    strap = ~s;
  endtask

  task automatic drain(); wait (obs_q.size() == 0); #1; endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    do_reset(1'b0);
    check("R10 idle release", int'(sda_oe), 0);
    loc_check("R11 cleared entry", 4'd14, 0);

    bus_start();
    expect_item("R1 ack C2", 1); wr_byte(8'hC2);
    expect_item("R5 ack header", 1); wr_byte(8'h0E);
    expect_item("R5 ack data0", 1); wr_byte(8'hA1);
    expect_item("R5 ack data1", 1); wr_byte(8'hB2);
    expect_item("R5 ack data2", 1); wr_byte(8'hC3);
    bus_stop(); drain();
    check("R10 released after stop", int'(sda_oe), 0);
    loc_check("R6 idx14", 4'd14, 8'hA1);
    loc_check("R6 idx15", 4'd15, 8'hB2);
    loc_check("R6 wrap idx0", 4'd0, 8'hC3);

    loc_write(4'd5, 8'h11);
    bus_start();
    expect_item("R3 C8 ignored", 0); wr_byte(8'hC8);
    expect_item("R5 no ack after mismatch", 0); wr_byte(8'h05);
    expect_item("R5 no ack data", 0); wr_byte(8'h77);
    bus_stop(); drain();
    loc_check("R5 reg untouched", 4'd5, 8'h11);
    loc_check("R11 local write", 4'd5, 8'h11);

    loc_write(4'd3, 8'h5A);
    loc_write(4'd4, 8'hA5);
    bus_start();
    expect_item("R1 ack C3", 1); wr_byte(8'hC3);
    expect_item("R7 ack header", 1); wr_byte(8'h03);
    expect_item("R7 byte0", 8'h5A); rd_byte(1'b1);
    expect_item("R7 byte1", 8'hA5); rd_byte(1'b1);
    expect_item("R7 byte2", 8'h11); rd_byte(1'b0);
    expect_item("R8 released after nack", 8'hFF); rd_byte(1'b0);
    bus_stop(); drain();

    bus_start();
    expect_item("R9 foreign addr", 0); wr_byte(8'h90);
    bus_rstart();
    expect_item("R9 ack after rstart", 1); wr_byte(8'hC2);
    expect_item("R9 ack header", 1); wr_byte(8'h07);
    expect_item("R9 ack data", 1); wr_byte(8'h3C);
    bus_stop(); drain();
    loc_check("R9 write landed", 4'd7, 8'h3C);

    do_reset(1'b1);
    loc_check("R11 reset clears", 4'd7, 0);
    bus_start();
    expect_item("R2 C2 ignored", 0); wr_byte(8'hC2);
    bus_stop();
    bus_start();
    expect_item("R2 ack C8", 1); wr_byte(8'hC8);
    expect_item("R2 ack header", 1); wr_byte(8'h02);
    expect_item("R2 ack data", 1); wr_byte(8'h99);
    bus_stop();
    bus_start();
    expect_item("R2 ack C9", 1); wr_byte(8'hC9);
    expect_item("R2 ack rd header", 1); wr_byte(8'h02);
    expect_item("R2 read back", 8'h99); rd_byte(1'b0);
    bus_stop(); drain();
    loc_check("R2 stored", 4'd2, 8'h99);
    check("R10 final release", int'(sda_oe), 0);

    summary();
  end
endmodule